// File: doc/BRIEF.md
# Early Load Disambiguator with Split Address Delivery

This block is the front end of a load/store queue. Its address network delivers each memory address in two pieces. A narrow early packet carries the queue tag, the cache set index and a few translation-index bits. A wide late packet carries the remaining high address bits. The block allocates queue entries in program order and retires them from the oldest end. For every load it tests the early bits against the early bits of all older stores.

When every older store has reported its low bits and none of them equals the load's, the block asks the cache to start its array read for that load at once. It does not wait for the high bits. When some older store does match on the low bits, the load is held. Once the load's high bits and the high bits of each matching store are present, the block resolves the hold. If the full addresses differ, the false match is released and the load starts its read. If they are equal, the block reports a true dependence. Each load receives one final verdict. This verdict comes one cycle after the last step it needs, and that cycle stands for the translation-select and tag-compare stage.

Top module: `early_load_disamb`

## Requirements
- R1: After reset there is no start request, no verdict, and the next allocation tag is 0.
- R2: Each accepted allocation takes the tag shown on `allocTag`. The tag advances by one modulo DEPTH. A retire frees the oldest entry.
- R3: The early packet carries the tag in its top TAG_W bits, the SET_W set bits below the tag, and the TLB_W translation bits at the bottom. A start request shows that load's tag, set bits and translation bits. It appears one cycle after the event that cleared the load.
- R4: The disambiguation uses only the SET_W set bits. Stores younger than the load are never compared against it.
- R5: A load does not start while any older store has not delivered its early packet. It starts one cycle after the last such packet arrives, provided nothing matches.
- R6: A load whose set bits equal those of an older store receives no start request until the high bits resolve the match.
- R7: On a false match the load starts one cycle after the last required high packet arrives. Its verdict (dependence 0) follows one cycle after the start.
- R8: On a true match (an older store has equal set and high bits), the verdict with dependence 1 comes one cycle after the last required high packet. No start request is ever issued for that load.
- R9: For a load that started early, the verdict with dependence 0 comes one cycle after the later of its start and its own high packet.
- R10: Retiring an older matching store releases a held load. The load starts one cycle after the retire.
- R11: When several loads become ready together, they start one per cycle with the lowest tag first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate the next queue entry |
| allocStore | input | 1 | Allocated entry is a store (1) or a load (0) |
| allocTag | output | TAG_W | Tag the next allocation receives |
| retireValid | input | 1 | Free the oldest entry |
| earlyValid | input | 1 | Early packet strobe |
| earlyPkt | input | TAG_W+SET_W+TLB_W | {tag, set bits, translation bits} |
| lateValid | input | 1 | Late packet strobe |
| lateTag | input | TAG_W | Entry the late packet belongs to |
| lateHigh | input | HIGH_W | High address bits |
| startValid | output | 1 | Cache array read request |
| startTag | output | TAG_W | Load tag of the request |
| startSet | output | SET_W | Set index for the array read |
| startTlb | output | TLB_W | Translation index bits |
| verdictValid | output | 1 | Final dependence verdict strobe |
| verdictTag | output | TAG_W | Load tag of the verdict |
| verdictDep | output | 1 | 1 when the load truly depends on an older store |

## Verification
The bench builds the block with DEPTH=8, SET_W=8, TLB_W=4 and HIGH_W=8. An eight-entry ring lets a short run of scenarios carry the tags past the wrap from 7 back to 0. The age comparison is therefore exercised across the wrap point, with older stores sitting at higher tags than the loads that follow them. The narrow high field keeps the true-match and false-match cases small to set up. The queue tag shrinks to three bits, so the early packet is 15 bits wide while its field order stays the same.

// File: rtl/pad_pkg.sv
package pad_pkg;
  // strobes from control to datapath, all qualified
  typedef struct packed {
    logic allocEn;
    logic allocStore;
    logic retireEn;
    logic earlyEn;
    logic lateEn;
  } padStrobe_t;
endpackage

// File: rtl/pad_datapath.sv
module pad_datapath
  import pad_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int SET_W  = 8,
  parameter int TLB_W  = 4,
  parameter int HIGH_W = 20,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  padStrobe_t        strb,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [TAG_W-1:0]  retireTag,
  input  logic [TAG_W-1:0]  earlyTag,
  input  logic [SET_W-1:0]  earlySet,
  input  logic [TLB_W-1:0]  earlyTlb,
  input  logic [TAG_W-1:0]  lateTag,
  input  logic [HIGH_W-1:0] lateHigh,
  input  logic [TAG_W-1:0]  rdIdx,
  output logic [SET_W-1:0]  rdSet,
  output logic [TLB_W-1:0]  rdTlb,
  output logic [DEPTH-1:0]  loadV,
  output logic [DEPTH-1:0]  lowKnownV,
  output logic [DEPTH-1:0]  highKnownV,
  output logic [DEPTH-1:0]  lowPendV,
  output logic [DEPTH-1:0]  lowHitV,
  output logic [DEPTH-1:0]  highPendV,
  output logic [DEPTH-1:0]  fullHitV
);
  logic [DEPTH-1:0]  entValid, entStore, lowKnown, highKnown;
  logic [SET_W-1:0]  entSet  [DEPTH];
  logic [TLB_W-1:0]  entTlb  [DEPTH];
  logic [HIGH_W-1:0] entHigh [DEPTH];
  logic [TAG_W-1:0]  relAge  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid  <= '0;
      entStore  <= '0;
      lowKnown  <= '0;
      highKnown <= '0;
    end else begin
      if (strb.allocEn) begin
        entValid[allocTag]  <= 1'b1;
        entStore[allocTag]  <= strb.allocStore;
        lowKnown[allocTag]  <= 1'b0;
        highKnown[allocTag] <= 1'b0;
      end
      if (strb.retireEn) entValid[retireTag] <= 1'b0;
      if (strb.earlyEn && entValid[earlyTag]) lowKnown[earlyTag] <= 1'b1;
      if (strb.lateEn && entValid[lateTag]) highKnown[lateTag] <= 1'b1;
    end
  end

  // payload fields need no reset: they are qualified by the known bits
  always_ff @(posedge clk) begin
    if (strb.earlyEn && entValid[earlyTag]) begin
      entSet[earlyTag] <= earlySet;
      entTlb[earlyTag] <= earlyTlb;
    end
    if (strb.lateEn && entValid[lateTag]) entHigh[lateTag] <= lateHigh;
  end

  // age relative to the oldest entry; smaller means older
  always_comb begin
    for (int i = 0; i < DEPTH; i++) relAge[i] = TAG_W'(i) - retireTag;
  end

  // load-versus-older-store status matrix
  always_comb begin
    lowPendV  = '0;
    lowHitV   = '0;
    highPendV = '0;
    fullHitV  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (entValid[j] && entStore[j] && (relAge[j] < relAge[i])) begin
          if (!lowKnown[j]) begin
            lowPendV[i] = 1'b1;
          end else if (entSet[j] == entSet[i]) begin
            lowHitV[i] = 1'b1;
            if (!highKnown[j]) highPendV[i] = 1'b1;
            else if (entHigh[j] == entHigh[i]) fullHitV[i] = 1'b1;
          end
        end
      end
    end
  end

  assign loadV      = entValid & ~entStore;
  assign lowKnownV  = lowKnown & entValid;
  assign highKnownV = highKnown & entValid;
  assign rdSet      = entSet[rdIdx];
  assign rdTlb      = entTlb[rdIdx];

  // R2
  retire_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.retireEn |=> !entValid[$past(retireTag)]);

  // R2
  alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> entValid[$past(allocTag)] && !lowKnown[$past(allocTag)]);
endmodule

// File: rtl/pad_control.sv
module pad_control
  import pad_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int SET_W  = 8,
  parameter int TLB_W  = 4,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic              allocStore,
  input  logic              retireValid,
  input  logic              earlyValid,
  input  logic              lateValid,
  input  logic [DEPTH-1:0]  loadV,
  input  logic [DEPTH-1:0]  lowKnownV,
  input  logic [DEPTH-1:0]  highKnownV,
  input  logic [DEPTH-1:0]  lowPendV,
  input  logic [DEPTH-1:0]  lowHitV,
  input  logic [DEPTH-1:0]  highPendV,
  input  logic [DEPTH-1:0]  fullHitV,
  input  logic [SET_W-1:0]  rdSet,
  input  logic [TLB_W-1:0]  rdTlb,
  output padStrobe_t        strb,
  output logic [TAG_W-1:0]  headPtr,
  output logic [TAG_W-1:0]  tailPtr,
  output logic [TAG_W-1:0]  startIdx,
  output logic              startValid,
  output logic [TAG_W-1:0]  startTag,
  output logic [SET_W-1:0]  startSet,
  output logic [TLB_W-1:0]  startTlb,
  output logic              verdictValid,
  output logic [TAG_W-1:0]  verdictTag,
  output logic              verdictDep
);
  localparam logic [TAG_W:0]   FULL_CNT = (TAG_W+1)'(DEPTH);
  localparam logic [DEPTH-1:0] ONE      = DEPTH'(1);

  logic [TAG_W:0]     count;
  logic [DEPTH-1:0]   started, decided;
  logic [DEPTH-1:0]   startReady, depReady, cleanReady, verdictReady;
  logic [TAG_W-1:0]   verdictIdx;
  logic               startAny, verdictAny;

  always_comb begin
    strb.allocEn    = allocValid && (count != FULL_CNT);
    strb.allocStore = allocStore;
    strb.retireEn   = retireValid && (count != '0);
    strb.earlyEn    = earlyValid;
    strb.lateEn     = lateValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strb.allocEn) tailPtr <= tailPtr + 1'b1;
      if (strb.retireEn) headPtr <= headPtr + 1'b1;
      count <= count + (TAG_W+1)'(strb.allocEn) - (TAG_W+1)'(strb.retireEn);
    end
  end

  // readiness of each load
  assign startReady = loadV & lowKnownV & ~started & ~decided & ~lowPendV &
                      (~lowHitV | (highKnownV & ~highPendV & ~fullHitV));
  assign depReady   = loadV & lowKnownV & highKnownV & ~started & ~decided &
                      ~lowPendV & ~highPendV & fullHitV;
  assign cleanReady = loadV & started & highKnownV & ~decided;
  assign verdictReady = depReady | cleanReady;

  // lowest-index pickers
  always_comb begin
    startIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (startReady[i]) startIdx = TAG_W'(i);
    verdictIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (verdictReady[i]) verdictIdx = TAG_W'(i);
  end
  assign startAny   = |startReady;
  assign verdictAny = |verdictReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started      <= '0;
      decided      <= '0;
      startValid   <= 1'b0;
      startTag     <= '0;
      startSet     <= '0;
      startTlb     <= '0;
      verdictValid <= 1'b0;
      verdictTag   <= '0;
      verdictDep   <= 1'b0;
    end else begin
      if (strb.allocEn) begin
        started[tailPtr] <= 1'b0;
        decided[tailPtr] <= 1'b0;
      end
      startValid <= startAny;
      if (startAny) begin
        started[startIdx] <= 1'b1;
        startTag <= startIdx;
        startSet <= rdSet;
        startTlb <= rdTlb;
      end
      verdictValid <= verdictAny;
      if (verdictAny) begin
        decided[verdictIdx] <= 1'b1;
        verdictTag <= verdictIdx;
        verdictDep <= depReady[verdictIdx];
      end
    end
  end

  // R5
  no_pending_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> ~|($past(lowPendV) & (ONE << startTag)));

  // R8
  true_dep_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && verdictDep) |-> |($past(fullHitV) & (ONE << verdictTag)));

  // R7
  start_verdict_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && !verdictDep && startValid) |-> (startTag != verdictTag));

  // R11
  single_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> !(startValid && (startTag == $past(startTag))));

  // R2
  occupancy_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
endmodule

// File: rtl/early_load_disamb.sv
module early_load_disamb
  import pad_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int SET_W  = 8,
  parameter int TLB_W  = 4,
  parameter int HIGH_W = 20,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PKT_W = TAG_W + SET_W + TLB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic              allocStore,
  output logic [TAG_W-1:0]  allocTag,
  input  logic              retireValid,
  input  logic              earlyValid,
  input  logic [PKT_W-1:0]  earlyPkt,
  input  logic              lateValid,
  input  logic [TAG_W-1:0]  lateTag,
  input  logic [HIGH_W-1:0] lateHigh,
  output logic              startValid,
  output logic [TAG_W-1:0]  startTag,
  output logic [SET_W-1:0]  startSet,
  output logic [TLB_W-1:0]  startTlb,
  output logic              verdictValid,
  output logic [TAG_W-1:0]  verdictTag,
  output logic              verdictDep
);
  padStrobe_t       strb;
  logic [TAG_W-1:0] headPtr, tailPtr, startIdx;
  logic [SET_W-1:0] rdSet;
  logic [TLB_W-1:0] rdTlb;
  logic [DEPTH-1:0] loadV, lowKnownV, highKnownV, lowPendV, lowHitV, highPendV, fullHitV;

  logic [TAG_W-1:0] earlyTag;
  logic [SET_W-1:0] earlySet;
  logic [TLB_W-1:0] earlyTlb;
  assign earlyTag = earlyPkt[PKT_W-1 -: TAG_W];
  assign earlySet = earlyPkt[TLB_W +: SET_W];
  assign earlyTlb = earlyPkt[TLB_W-1:0];
  assign allocTag = tailPtr;

  pad_control #(.DEPTH(DEPTH), .SET_W(SET_W), .TLB_W(TLB_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocStore(allocStore),
    .retireValid(retireValid), .earlyValid(earlyValid), .lateValid(lateValid),
    .loadV(loadV), .lowKnownV(lowKnownV), .highKnownV(highKnownV),
    .lowPendV(lowPendV), .lowHitV(lowHitV), .highPendV(highPendV), .fullHitV(fullHitV),
    .rdSet(rdSet), .rdTlb(rdTlb),
    .strb(strb), .headPtr(headPtr), .tailPtr(tailPtr), .startIdx(startIdx),
    .startValid(startValid), .startTag(startTag), .startSet(startSet), .startTlb(startTlb),
    .verdictValid(verdictValid), .verdictTag(verdictTag), .verdictDep(verdictDep)
  );

  pad_datapath #(.DEPTH(DEPTH), .SET_W(SET_W), .TLB_W(TLB_W), .HIGH_W(HIGH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocTag(tailPtr), .retireTag(headPtr),
    .earlyTag(earlyTag), .earlySet(earlySet), .earlyTlb(earlyTlb),
    .lateTag(lateTag), .lateHigh(lateHigh),
    .rdIdx(startIdx), .rdSet(rdSet), .rdTlb(rdTlb),
    .loadV(loadV), .lowKnownV(lowKnownV), .highKnownV(highKnownV),
    .lowPendV(lowPendV), .lowHitV(lowHitV), .highPendV(highPendV), .fullHitV(fullHitV)
  );
endmodule

// File: tb/test_early_load_disamb.sv
module test_early_load_disamb;
  localparam int DEPTH = 8, SET_W = 8, TLB_W = 4, HIGH_W = 8;
  localparam int TAG_W = $clog2(DEPTH);
  localparam int PKT_W = TAG_W + SET_W + TLB_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 1'b0, allocStore = 1'b0, retireValid = 1'b0;
  logic earlyValid = 1'b0, lateValid = 1'b0;
  logic [PKT_W-1:0]  earlyPkt = '0;
  logic [TAG_W-1:0]  lateTag = '0;
  logic [HIGH_W-1:0] lateHigh = '0;
  logic [TAG_W-1:0]  allocTag, startTag, verdictTag;
  logic [SET_W-1:0]  startSet;
  logic [TLB_W-1:0]  startTlb;
  logic startValid, verdictValid, verdictDep;

  int nChecks = 0, nFail = 0, nextTag = 0;

  always #10 clk = ~clk;

  early_load_disamb #(.DEPTH(DEPTH), .SET_W(SET_W), .TLB_W(TLB_W), .HIGH_W(HIGH_W)) i_early_load_disamb (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocStore(allocStore), .allocTag(allocTag),
    .retireValid(retireValid), .earlyValid(earlyValid), .earlyPkt(earlyPkt),
    .lateValid(lateValid), .lateTag(lateTag), .lateHigh(lateHigh),
    .startValid(startValid), .startTag(startTag), .startSet(startSet), .startTlb(startTlb),
    .verdictValid(verdictValid), .verdictTag(verdictTag), .verdictDep(verdictDep));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic alloc(input logic st, output int tag);
    chk("R2", "allocTag", 32'(allocTag), 32'(nextTag));
    tag = nextTag;
    nextTag = (nextTag + 1) % DEPTH;
    allocValid = 1'b1; allocStore = st;
    tick();
    allocValid = 1'b0;
  endtask

  task automatic early(input int tag, input logic [SET_W-1:0] s, input logic [TLB_W-1:0] t);
    earlyValid = 1'b1; earlyPkt = {TAG_W'(tag), s, t};
    tick();
    earlyValid = 1'b0;
  endtask

  task automatic late(input int tag, input logic [HIGH_W-1:0] h);
    lateValid = 1'b1; lateTag = TAG_W'(tag); lateHigh = h;
    tick();
    lateValid = 1'b0;
  endtask

  task automatic retire();
    retireValid = 1'b1;
    tick();
    retireValid = 1'b0;
  endtask

  task automatic expStart(input string req, input int tag, input int s);
    chk(req, "startValid", 32'(startValid), 1);
    chk(req, "startTag", 32'(startTag), 32'(tag));
    chk(req, "startSet", 32'(startSet), 32'(s));
  endtask

  task automatic expVerdict(input string req, input int tag, input logic dep);
    chk(req, "verdictValid", 32'(verdictValid), 1);
    chk(req, "verdictTag", 32'(verdictTag), 32'(tag));
    chk(req, "verdictDep", 32'(verdictDep), 32'(dep));
  endtask

  // R3, R9: lone load starts early, verdict after its high bits
  task automatic t_lone_load();
    int ld;
    alloc(1'b0, ld);
    early(ld, 8'h12, 4'h3);
    chk("R3", "no start in capture cycle", 32'(startValid), 0);
    tick();
    expStart("R3", ld, 8'h12);
    chk("R3", "startTlb", 32'(startTlb), 3);
    chk("R9", "no verdict before high", 32'(verdictValid), 0);
    late(ld, 8'h40);
    tick();
    expVerdict("R9", ld, 1'b0);
    retire();
  endtask

  // R5: older store without low bits blocks the load
  task automatic t_pending_store();
    int st, ld;
    alloc(1'b1, st); alloc(1'b0, ld);
    early(ld, 8'h55, 4'h1); tick();
    chk("R5", "blocked start", 32'(startValid), 0);
    tick();
    chk("R5", "still blocked", 32'(startValid), 0);
    early(st, 8'h66, 4'h0); tick();
    expStart("R5", ld, 8'h55);
    late(ld, 8'h01); tick();
    expVerdict("R9", ld, 1'b0);
    retire(); retire();
  endtask

  // R4: younger store with equal set bits is ignored
  task automatic t_younger_store();
    int ld, st;
    alloc(1'b0, ld); alloc(1'b1, st);
    early(st, 8'h55, 4'h2); tick();
    early(ld, 8'h55, 4'h2); tick();
    expStart("R4", ld, 8'h55);
    late(ld, 8'h07); tick();
    expVerdict("R4", ld, 1'b0);
    retire(); retire();
  endtask

  // R6, R7: false match released after high bits differ
  task automatic t_false_match();
    int st, ld;
    alloc(1'b1, st); alloc(1'b0, ld);
    early(st, 8'h21, 4'h0); tick();
    early(ld, 8'h21, 4'h5); tick();
    chk("R6", "held on low match", 32'(startValid), 0);
    late(ld, 8'h01); tick();
    chk("R6", "held until store high", 32'(startValid), 0);
    chk("R6", "no verdict yet", 32'(verdictValid), 0);
    late(st, 8'h02); tick();
    expStart("R7", ld, 8'h21);
    tick();
    expVerdict("R7", ld, 1'b0);
    retire(); retire();
  endtask

  // R8: true dependence, no start; this pair wraps the tags
  task automatic t_true_match();
    int st, ld;
    alloc(1'b1, st); alloc(1'b0, ld);
    chk("R2", "tag wrapped to 0", 32'(ld), 0);
    early(st, 8'h33, 4'h0); tick();
    early(ld, 8'h33, 4'h0); tick();
    late(st, 8'h09); tick();
    chk("R8", "no start", 32'(startValid), 0);
    late(ld, 8'h09); tick();
    expVerdict("R8", ld, 1'b1);
    chk("R8", "no start at verdict", 32'(startValid), 0);
    tick();
    chk("R8", "no start after verdict", 32'(startValid), 0);
    retire(); retire();
  endtask

  // R10: retiring the matching store releases the load
  task automatic t_retire_release();
    int st, ld;
    alloc(1'b1, st); alloc(1'b0, ld);
    early(st, 8'h44, 4'h0); tick();
    early(ld, 8'h44, 4'h6); tick();
    chk("R10", "held before retire", 32'(startValid), 0);
    retire(); tick();
    expStart("R10", ld, 8'h44);
    late(ld, 8'h0A); tick();
    expVerdict("R10", ld, 1'b0);
    retire();
  endtask

  // R11: two loads cleared together start lowest tag first
  task automatic t_arbitration();
    int st, l1, l2;
    alloc(1'b1, st); alloc(1'b0, l1); alloc(1'b0, l2);
    early(l1, 8'h10, 4'h0); tick();
    early(l2, 8'h11, 4'h0); tick();
    chk("R11", "both blocked", 32'(startValid), 0);
    early(st, 8'h77, 4'h0); tick();
    expStart("R11", l1, 8'h10);
    tick();
    expStart("R11", l2, 8'h11);
    retire(); retire(); retire();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1", "startValid", 32'(startValid), 0);
    chk("R1", "verdictValid", 32'(verdictValid), 0);
    chk("R1", "allocTag", 32'(allocTag), 0);
    t_lone_load();
    t_pending_store();
    t_younger_store();
    t_false_match();
    t_true_match();
    t_retire_release();
    t_arbitration();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule